// File: doc/BRIEF.md
# Receive Quiet-Period Timer

This block is a down-counter with a preload input, built for a serial receiver channel. In its normal mode software-style start and stop strobes run and halt it, and on every expiry it reloads itself from the preload value, so it acts as a periodic timer. A command field can switch it into a receive-watchdog mode. In that mode the receiver's character-transfer strobe reloads and restarts it each time a character moves into the receive holding register. The counter therefore expires only after the line has been quiet for the programmed number of ticks. When it expires it raises a ready flag for the interrupt logic and parks at zero.

Counting advances only on a clock-enable tick, so the time base is chosen outside the block. Entering the watchdog mode stops the counter, clears the ready flag and locks out the start and stop strobes. Leaving the mode gives the strobes back, but it leaves the counter running or halted as it was and keeps any pending ready flag. All other command codes are inert.

Top module: `rx_quiet_timer`

## Requirements
- R1: After a synchronous active-low reset, count is 0, running is 0, ready is 0 and tmo_mode is 0.
- R2: In normal mode (tmo_mode=0), start loads count from preload and sets running. If stop is high in the same cycle, stop wins and start is dropped.
- R3: On each cycle with tick high while running, count falls by one. With no tick, or while not running, and no load, count holds.
- R4: In normal mode, a tick while running with count at 0 or 1 is an expiry. It sets ready, reloads count from preload and keeps running.
- R5: In normal mode, stop clears running and ready, leaves count as it is, and takes priority over a tick in the same cycle.
- R6: cmd_valid with cmd=4'b1010 sets tmo_mode, clears running and ready, and leaves count unchanged. It overrides any start, stop, xfer or tick in the same cycle.
- R7: While tmo_mode=1, start and stop have no effect on count, running or ready.
- R8: While tmo_mode=1, xfer loads count from preload and sets running. It also takes priority over a tick. While tmo_mode=0, xfer has no effect.
- R9: While tmo_mode=1, a tick while running with count at 0 or 1 sets ready, forces count to 0 and clears running.
- R10: cmd_valid with cmd=4'b1100 clears tmo_mode without changing running or ready. Strobes in that same cycle are still handled under timeout-mode rules.
- R11: Command codes other than 4'b1010 and 4'b1100 have no effect, and no code has any effect while cmd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one cycle per count step |
| xfer | input | 1 | Receiver moved a character into its holding register |
| cmd_valid | input | 1 | Qualifies cmd for one cycle |
| cmd | input | 4 | Channel command code |
| start | input | 1 | Start counting from preload (normal mode only) |
| stop | input | 1 | Halt counting and clear ready (normal mode only) |
| preload | input | 16 | Reload value |
| count | output | 16 | Present counter value |
| running | output | 1 | Counter is advancing on ticks |
| ready | output | 1 | Counter-ready flag for interrupt logic |
| tmo_mode | output | 1 | Receive-timeout mode active |

## Verification
The hardest case to reach is a command landing in the same cycle as other activity. Examples are a mode exit arriving while the counter runs with a ready flag still pending, and a mode entry colliding with a start strobe. The bench reaches these by issuing a mode-exit command mid-count after an earlier expiry has left ready set, and by firing the entry command together with start. A behavioural model follows every cycle of this, so timing of the sharing and priority rules is compared continuously, not just at end points. Tick spacing is varied across runs so that expiry can land on either side of a character transfer.

// File: rtl/rqt_pkg.sv
// Package rqt_pkg
// Shared command codes and widths for the receive quiet-period timer.
// Assumes a 4-bit command field; the two active codes are fixed values.
package rqt_pkg;
    localparam int unsigned CMD_W = 4;
    localparam logic [CMD_W-1:0] CMD_TMO_ENTER = 4'b1010;
    localparam logic [CMD_W-1:0] CMD_TMO_LEAVE = 4'b1100;
endpackage

// File: rtl/rqt_cmd_decode.sv
// Module rqt_cmd_decode
// Turns a qualified command code into single-cycle enter/leave pulses.
// Assumes cmd_valid is high for exactly the cycle the command is meant for;
// every other code is dropped here.
module rqt_cmd_decode
    import rqt_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd,
    output logic             enter,
    output logic             leave
);
    // Match the two active codes; all others decode to nothing.
    always_comb begin
        enter = cmd_valid && (cmd == CMD_TMO_ENTER);
        leave = cmd_valid && (cmd == CMD_TMO_LEAVE);
    end
endmodule

// File: rtl/rqt_mode_ctrl.sv
// Module rqt_mode_ctrl
// Holds the timeout-mode bit and routes start/stop/xfer strobes into
// load and halt requests for the counter. The registered mode gates the
// strobes, so a mode change takes effect from the next cycle.
// Assumes strobes are single-cycle pulses.
module rqt_mode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic leave,
    input  logic start,
    input  logic stop,
    input  logic xfer,
    output logic mode_q,
    output logic load,
    output logic halt
);
    // Route strobes according to the current mode; entry overrides all.
    always_comb begin
        halt = enter || (!mode_q && stop);
        if (enter) begin
            load = 1'b0;
        end else if (mode_q) begin
            load = xfer;
        end else begin
            load = start && !stop;
        end
    end

    // Mode register: entry sets, exit clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (enter) begin
            mode_q <= 1'b1;
        end else if (leave) begin
            mode_q <= 1'b0;
        end
    end

    // R7: in timeout mode a stop strobe never becomes a halt request
    a_r7_no_halt_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q && !enter && stop |-> !halt);

    // R10: leaving the mode takes effect at the next edge
    a_r10_leave_clears: assert property (@(posedge clk) disable iff (!rst_n)
        leave && !enter |=> !mode_q);
endmodule

// File: rtl/rqt_down_counter.sv
// Module rqt_down_counter
// Down-counter with run and ready state. Halt beats load, and load beats
// a tick. An expiry is a tick while running with count 0 or 1: it sets
// ready and then either parks at zero (stop_at_zero) or reloads.
// Assumes preload is stable in any cycle where load is high.
module rqt_down_counter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             halt,
    input  logic             stop_at_zero,
    input  logic [WIDTH-1:0] preload,
    output logic [WIDTH-1:0] cnt_q,
    output logic             run_q,
    output logic             ready_q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic expire;

    // Expiry detection for the current cycle.
    always_comb expire = tick && run_q && (cnt_q <= ONE);

    // Count, run and ready state update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            run_q   <= 1'b0;
            ready_q <= 1'b0;
        end else if (halt) begin
            run_q   <= 1'b0;
            ready_q <= 1'b0;
        end else if (load) begin
            cnt_q <= preload;
            run_q <= 1'b1;
        end else if (expire) begin
            ready_q <= 1'b1;
            if (stop_at_zero) begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end else begin
                cnt_q <= preload;
            end
        end else if (tick && run_q) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // R3: with nothing acting on it the count holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !(tick && run_q) |=> $stable(cnt_q));

    // R9: expiry in stop-at-zero mode parks the counter with ready set
    a_r9_park: assert property (@(posedge clk) disable iff (!rst_n)
        !halt && !load && tick && run_q && (cnt_q <= ONE) && stop_at_zero
        |=> !run_q && ready_q && (cnt_q == '0));

    // R4: periodic expiry reloads and keeps running
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        !halt && !load && tick && run_q && (cnt_q <= ONE) && !stop_at_zero
        |=> run_q && ready_q && (cnt_q == $past(preload)));

    // R5: a halt request always leaves the counter idle with ready clear
    a_r5_halt: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !run_q && !ready_q);
endmodule

// File: rtl/rx_quiet_timer.sv
// Module rx_quiet_timer
// Receive quiet-period timer: a down-counter with a periodic normal mode
// and a receive-timeout mode restarted by each character transfer.
// Assumes all strobes are synchronous single-cycle pulses on clk.
module rx_quiet_timer #(
    parameter int unsigned WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     xfer,
    input  logic                     cmd_valid,
    input  logic [rqt_pkg::CMD_W-1:0] cmd,
    input  logic                     start,
    input  logic                     stop,
    input  logic [WIDTH-1:0]         preload,
    output logic [WIDTH-1:0]         count,
    output logic                     running,
    output logic                     ready,
    output logic                     tmo_mode
);
    import rqt_pkg::*;

    logic enter;
    logic leave;
    logic load;
    logic halt;

    rqt_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .enter     (enter),
        .leave     (leave)
    );

    rqt_mode_ctrl u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .enter  (enter),
        .leave  (leave),
        .start  (start),
        .stop   (stop),
        .xfer   (xfer),
        .mode_q (tmo_mode),
        .load   (load),
        .halt   (halt)
    );

    rqt_down_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .load         (load),
        .halt         (halt),
        .stop_at_zero (tmo_mode),
        .preload      (preload),
        .cnt_q        (count),
        .run_q        (running),
        .ready_q      (ready)
    );

    // R6: mode entry stops the counter, clears ready and keeps count
    a_r6_enter: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd == CMD_TMO_ENTER)
        |=> tmo_mode && !running && !ready && $stable(count));

    // R7: start/stop alone do nothing in timeout mode
    a_r7_locked: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_mode && (start || stop) && !xfer && !tick && !cmd_valid
        |=> $stable(count) && $stable(running) && $stable(ready));

    // R10: mode exit leaves run and ready untouched
    a_r10_leave_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_mode && cmd_valid && (cmd == CMD_TMO_LEAVE) && !xfer && !tick
        |=> !tmo_mode && $stable(running) && $stable(ready));

    // R11: inert codes change nothing
    a_r11_inert: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd != CMD_TMO_ENTER) && (cmd != CMD_TMO_LEAVE)
        && !start && !stop && !xfer && !tick
        |=> $stable(count) && $stable(running) && $stable(ready) && $stable(tmo_mode));
endmodule

// File: tb/rx_quiet_timer_bench.sv
// Bench for rx_quiet_timer: a behavioural model stepped on every rising
// edge and compared with the outputs on every falling edge.
module rx_quiet_timer_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         xfer = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [3:0]   cmd = 4'b0000;
    logic         start = 1'b0;
    logic         stop = 1'b0;
    logic [W-1:0] preload = '0;
    logic [W-1:0] count;
    logic         running;
    logic         ready;
    logic         tmo_mode;

    rx_quiet_timer #(.WIDTH(W)) u_rx_quiet_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .xfer(xfer),
        .cmd_valid(cmd_valid), .cmd(cmd), .start(start), .stop(stop),
        .preload(preload), .count(count), .running(running),
        .ready(ready), .tmo_mode(tmo_mode)
    );

    always #4 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    int    tick_div = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    // behavioural model state
    int m_count = 0;
    bit m_run = 0;
    bit m_ready = 0;
    bit m_mode = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 0; m_run = 0; m_ready = 0; m_mode = 0;
        end else if (cmd_valid && cmd == 4'b1010) begin
            m_run = 0; m_ready = 0; m_mode = 1;
        end else begin
            if (!m_mode) begin
                if (stop) begin m_run = 0; m_ready = 0; end
                else if (start) begin m_count = preload; m_run = 1; end
                else if (tick && m_run) begin
                    if (m_count <= 1) begin m_ready = 1; m_count = preload; end
                    else m_count = m_count - 1;
                end
            end else begin
                if (xfer) begin m_count = preload; m_run = 1; end
                else if (tick && m_run) begin
                    if (m_count <= 1) begin m_ready = 1; m_count = 0; m_run = 0; end
                    else m_count = m_count - 1;
                end
            end
            if (cmd_valid && cmd == 4'b1100) m_mode = 0;
        end
    end

    // compare every cycle and drive the tick pattern
    always @(negedge clk) begin
        cycles++;
        if (cmp_en && !done) begin
            checks++;
            if (count !== W'(m_count) || running !== m_run || ready !== m_ready
                || tmo_mode !== m_mode) begin
                errors++;
                $display("FAIL %s cyc %0d actual cnt=%0d run=%0b rdy=%0b mode=%0b expected cnt=%0d run=%0b rdy=%0b mode=%0b",
                         tag, cycles, count, running, ready, tmo_mode,
                         m_count, m_run, m_ready, m_mode);
            end
        end
        tick <= (tick_div > 0) && (cycles % tick_div == 0);
        if (cycles > 50000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [3:0] code, input logic v,
                         input logic s_start, input logic s_stop, input logic s_xfer);
        @(negedge clk);
        cmd_valid = v; cmd = code; start = s_start; stop = s_stop; xfer = s_xfer;
        @(negedge clk);
        cmd_valid = 0; cmd = 4'b0000; start = 0; stop = 0; xfer = 0;
    endtask

    initial begin
        wait_cyc(3);
        cmp_en = 1'b1;
        tag = "R1";
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(2);

        // periodic counting with a tick every cycle
        tag = "R2/R3/R4 fast tick";
        preload = 16'd5; tick_div = 1;
        issue(4'b0000, 0, 1, 0, 0);
        wait_cyc(14);

        // slower tick pattern
        tag = "R3 slow tick";
        tick_div = 3; preload = 16'd3;
        wait_cyc(20);

        // stop, and start with stop together
        tag = "R5 stop";
        issue(4'b0000, 0, 0, 1, 0);
        wait_cyc(4);
        tag = "R2 start+stop";
        issue(4'b0000, 0, 1, 1, 0);
        wait_cyc(3);
        tag = "R8 xfer ignored normal";
        issue(4'b0000, 0, 0, 0, 1);
        wait_cyc(3);
        tag = "R4 preload zero";
        preload = 16'd0; tick_div = 2;
        issue(4'b0000, 0, 1, 0, 0);
        wait_cyc(6);

        // enter timeout mode while running, colliding with start
        tag = "R6 enter";
        preload = 16'd4;
        issue(4'b1010, 1, 1, 0, 0);
        wait_cyc(4);
        tag = "R7 strobes locked";
        issue(4'b0000, 0, 1, 0, 0);
        issue(4'b0000, 0, 0, 1, 0);
        wait_cyc(3);
        tag = "R8 xfer restarts";
        issue(4'b0000, 0, 0, 0, 1);
        wait_cyc(5);
        issue(4'b0000, 0, 0, 0, 1);
        tag = "R9 quiet expiry";
        wait_cyc(16);
        tag = "R7 stop keeps ready";
        issue(4'b0000, 0, 0, 1, 0);
        wait_cyc(2);

        // leave while idle with ready pending
        tag = "R10 leave idle";
        issue(4'b1100, 1, 0, 0, 0);
        wait_cyc(3);

        // leave while running with ready pending, with a stop in the same cycle
        tag = "R6 re-enter";
        issue(4'b1010, 1, 0, 0, 0);
        preload = 16'd3; tick_div = 4;
        issue(4'b0000, 0, 0, 0, 1);
        tag = "R9 expiry then restart";
        wait_cyc(16);
        issue(4'b0000, 0, 0, 0, 1);
        wait_cyc(2);
        tag = "R10 leave running";
        issue(4'b1100, 1, 0, 1, 0);
        wait_cyc(20);

        // inert codes and an unqualified active code
        tag = "R11 inert codes";
        issue(4'b1011, 1, 0, 0, 0);
        issue(4'b1101, 1, 0, 0, 0);
        issue(4'b1110, 1, 0, 0, 0);
        issue(4'b1111, 1, 0, 0, 0);
        issue(4'b0000, 1, 0, 0, 0);
        issue(4'b1010, 0, 0, 0, 0);
        wait_cyc(6);

        // reset mid-run
        tag = "R1 reset again";
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule